// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes PCM audio from external converters and turns it into parallel samples. The inputs are a bit clock, a frame clock and one serial data line. The same logic handles three two-channel framings: I2S, left-justified and right-justified. It also handles time-division multiplexed frames of 8 or 16 slots on a single line. Each word is 16, 20 or 24 bits long, arrives MSB first in two's complement, and leaves as a 28-bit sample. The sample carries its channel number and a valid strobe that lasts one system clock.

The three serial pins are treated as ordinary data. They pass through a synchronizer clocked by the fast system clock, and a rising bit clock is detected inside that domain. A single counter tracks the position of each bit, measured from the frame clock edge that opened the current half-frame or frame. A shift register keeps the most recent serial bits. When the counter reaches the last bit of a word for the selected framing and width, the word is left-aligned to bit 23 and its sign is copied into bits 27:24.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is asserted and directly after it is released, `smp_valid` is 0, `smp_chan` is 0 and `smp_data` is 0.
- R2: The frame clock and the data line are sampled only on rising bit clock edges. The first rising edge after reset only records the frame clock level and never opens a frame, so no sample is emitted before the frame clock first changes.
- R3: With `fmt_sel` = 0 (I2S), frame clock low is channel 0 and high is channel 1. The MSB is sampled on the second rising edge after the frame clock changes level.
- R4: With `fmt_sel` = 1 (left-justified), frame clock high is channel 0 and low is channel 1. The MSB is sampled on the first rising edge that sees the new frame clock level.
- R5: With `fmt_sel` = 2 (right-justified), the channel polarity is the same as in R4. Each half-frame is 32 bit clocks, and the LSB is the 32nd bit of the half-frame.
- R6: With `fmt_sel` = 3 (8 slots) or 4 (16 slots), a rising frame clock marks the first bit of slot 0. Each slot is 32 bits with the word starting at the slot's first bit, and `smp_chan` equals the slot number.
- R7: With `fmt_sel` = 3, any slot numbered 8 or higher in a longer frame produces no sample.
- R8: `width_sel` 0 selects 16-bit words, 1 selects 20-bit words, and both 2 and 3 select 24-bit words.
- R9: The word's MSB lands on `smp_data` bit 23. Bits 27:24 repeat that MSB, and every bit below the word's LSB is 0.
- R10: Each received word raises `smp_valid` for exactly one clock, with `smp_chan` and `smp_data` valid in that cycle.
- R11: Data bits outside a word's window (padding and the rest of the slot) do not affect any sample.
- R12: `fmt_sel` codes 5, 6 and 7 produce no samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock from the converter |
| frame_clk | input | 1 | Frame / channel-select clock |
| ser_data | input | 1 | Serial audio data line |
| fmt_sel | input | 3 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM 8-slot, 4 TDM 16-slot |
| width_sel | input | 2 | Word width: 0 = 16, 1 = 20, 2/3 = 24 bits |
| smp_valid | output | 1 | One-clock strobe marking a new sample |
| smp_chan | output | 4 | Channel or slot index of the sample |
| smp_data | output | 28 | Sign-extended, left-aligned sample |

## Verification
The checker watches every cycle for these properties:
- the strobe never lasts more than one cycle;
- the four top bits always copy bit 23;
- the bits below a 16- or 20-bit word are zero;
- the channel index stays within two channels or eight slots as the framing requires;
- nothing is emitted for the unused format codes.

Some behaviour depends on what was sent, so only the bench scenarios can show it: where each framing places the MSB, which frame clock level maps to which channel, that padding bits are ignored, the priming on the first edge, and that surplus slots are dropped in 8-slot mode.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  localparam logic [2:0] FMT_I2S   = 3'd0;
  localparam logic [2:0] FMT_LJ    = 3'd1;
  localparam logic [2:0] FMT_RJ    = 3'd2;
  localparam logic [2:0] FMT_TDM8  = 3'd3;
  localparam logic [2:0] FMT_TDM16 = 3'd4;

  // Number of significant bits for a width selection code.
  function automatic logic [4:0] word_bits(input logic [1:0] wsel);
    case (wsel)
      2'd0:    word_bits = 5'd16;
      2'd1:    word_bits = 5'd20;
      default: word_bits = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_clk_i,
  input  logic frame_clk_i,
  input  logic ser_data_i,
  output logic bit_stb_o,
  output logic lr_o,
  output logic sd_o
);

  localparam int LANES = 3;
  localparam int CHAIN_W = LANES * STAGES;

  logic [LANES-1:0]   pins;
  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic [LANES-1:0]   synced;
  logic               bclk_prev_q, bclk_prev_d;

  assign pins   = {bit_clk_i, frame_clk_i, ser_data_i};
  assign synced = chain_q[CHAIN_W-1 -: LANES];

  always_comb begin
    chain_d     = {chain_q[CHAIN_W-LANES-1:0], pins};
    bclk_prev_d = synced[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q     <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      chain_q     <= chain_d;
      bclk_prev_q <= bclk_prev_d;
    end
  end

  assign bit_stb_o = synced[2] & ~bclk_prev_q;
  assign lr_o      = synced[1];
  assign sd_o      = synced[0];

endmodule

// File: rtl/asrx_frame_trk.sv
module asrx_frame_trk
  import asrx_pkg::*;
#(
  parameter int SLOT_LEN  = 32,
  parameter int MAX_SLOTS = 16,
  localparam int POS_W    = $clog2(SLOT_LEN),
  localparam int CH_W     = $clog2(MAX_SLOTS),
  localparam int CNT_W    = POS_W + CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_stb_i,
  input  logic            lr_i,
  input  logic [2:0]      fmt_i,
  input  logic [1:0]      wsel_i,
  output logic            done_o,
  output logic [CH_W-1:0] chan_o
);

  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(SLOT_LEN - 1);
  localparam logic [CH_W-1:0]  HALF_SLOT = CH_W'(MAX_SLOTS / 2);

  logic             primed_q, primed_d;
  logic             armed_q, armed_d;
  logic             lr_prev_q, lr_prev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic             two_ch, tdm, start, hit;
  logic [CNT_W-1:0] k;
  logic [POS_W-1:0] pos, wb_pos, wb_last;
  logic [CH_W-1:0]  slot;
  logic [4:0]       wb;

  always_comb begin
    two_ch = (fmt_i == FMT_I2S) || (fmt_i == FMT_LJ) || (fmt_i == FMT_RJ);
    tdm    = (fmt_i == FMT_TDM8) || (fmt_i == FMT_TDM16);
    start  = primed_q & ((two_ch & (lr_i ^ lr_prev_q)) |
                         (tdm & lr_i & ~lr_prev_q));
    if (start)        k = '0;
    else if (&cnt_q)  k = cnt_q;
    else              k = cnt_q + 1'b1;
    pos     = k[POS_W-1:0];
    slot    = k[CNT_W-1:POS_W];
    wb      = word_bits(wsel_i);
    wb_pos  = POS_W'(wb);
    wb_last = POS_W'(wb - 5'd1);
    case (fmt_i)
      FMT_I2S:   hit = (slot == '0) && (pos == wb_pos);
      FMT_LJ:    hit = (slot == '0) && (pos == wb_last);
      FMT_RJ:    hit = (slot == '0) && (pos == LAST_POS);
      FMT_TDM8:  hit = (slot < HALF_SLOT) && (pos == wb_last);
      FMT_TDM16: hit = (pos == wb_last);
      default:   hit = 1'b0;
    endcase
    done_o = bit_stb_i & (armed_q | start) & hit;
    if (tdm) chan_o = slot;
    else     chan_o = {{(CH_W-1){1'b0}}, (fmt_i == FMT_I2S) ? lr_i : ~lr_i};
  end

  // Next state, clock-enabled by the bit strobe
  always_comb begin
    primed_d  = primed_q;
    armed_d   = armed_q;
    lr_prev_d = lr_prev_q;
    cnt_d     = cnt_q;
    if (bit_stb_i) begin
      primed_d  = 1'b1;
      armed_d   = armed_q | start;
      lr_prev_d = lr_i;
      cnt_d     = k;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      armed_q   <= 1'b0;
      lr_prev_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      primed_q  <= primed_d;
      armed_q   <= armed_d;
      lr_prev_q <= lr_prev_d;
      cnt_q     <= cnt_d;
    end
  end

endmodule

// File: rtl/asrx_word_asm.sv
module asrx_word_asm
  import asrx_pkg::*;
#(
  parameter int SAMPLE_W = 28,
  parameter int WORD_MAX = 24,
  parameter int CH_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_stb_i,
  input  logic                sd_i,
  input  logic                done_i,
  input  logic [CH_W-1:0]     chan_i,
  input  logic [1:0]          wsel_i,
  output logic                valid_o,
  output logic [CH_W-1:0]     chan_o,
  output logic [SAMPLE_W-1:0] data_o
);

  localparam int EXT_W = SAMPLE_W - WORD_MAX;

  logic [WORD_MAX-1:0] sh_q, sh_d, sh_nx, aligned;
  logic [4:0]          shamt;
  logic                valid_q, valid_d;
  logic [CH_W-1:0]     chan_q, chan_d;
  logic [SAMPLE_W-1:0] data_q, data_d;

  always_comb begin
    sh_nx   = {sh_q[WORD_MAX-2:0], sd_i};
    shamt   = 5'(WORD_MAX) - word_bits(wsel_i);
    aligned = sh_nx << shamt;
    sh_d    = bit_stb_i ? sh_nx : sh_q;
    valid_d = done_i;
    chan_d  = chan_q;
    data_d  = data_q;
    if (done_i) begin
      chan_d = chan_i;
      data_d = {{EXT_W{aligned[WORD_MAX-1]}}, aligned};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      valid_q <= 1'b0;
      chan_q  <= '0;
      data_q  <= '0;
    end else begin
      sh_q    <= sh_d;
      valid_q <= valid_d;
      chan_q  <= chan_d;
      data_q  <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign chan_o  = chan_q;
  assign data_o  = data_q;

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx #(
  parameter int SAMPLE_W    = 28,
  parameter int WORD_MAX    = 24,
  parameter int SLOT_LEN    = 32,
  parameter int MAX_SLOTS   = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(MAX_SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_clk,
  input  logic                frame_clk,
  input  logic                ser_data,
  input  logic [2:0]          fmt_sel,
  input  logic [1:0]          width_sel,
  output logic                smp_valid,
  output logic [CH_W-1:0]     smp_chan,
  output logic [SAMPLE_W-1:0] smp_data
);

  logic [1:0]      rst_pipe_q;
  logic            core_rst_n;
  logic            bit_stb, lr_s, sd_s, done;
  logic [CH_W-1:0] chan;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  asrx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .bit_clk_i   (bit_clk),
    .frame_clk_i (frame_clk),
    .ser_data_i  (ser_data),
    .bit_stb_o   (bit_stb),
    .lr_o        (lr_s),
    .sd_o        (sd_s)
  );

  asrx_frame_trk #(.SLOT_LEN(SLOT_LEN), .MAX_SLOTS(MAX_SLOTS)) trk_i (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .bit_stb_i (bit_stb),
    .lr_i      (lr_s),
    .fmt_i     (fmt_sel),
    .wsel_i    (width_sel),
    .done_o    (done),
    .chan_o    (chan)
  );

  asrx_word_asm #(.SAMPLE_W(SAMPLE_W), .WORD_MAX(WORD_MAX), .CH_W(CH_W)) asm_i (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .bit_stb_i (bit_stb),
    .sd_i      (sd_s),
    .done_i    (done),
    .chan_i    (chan),
    .wsel_i    (width_sel),
    .valid_o   (smp_valid),
    .chan_o    (smp_chan),
    .data_o    (smp_data)
  );

endmodule

// File: rtl/asrx_chk.sv
module asrx_chk #(
  parameter int SAMPLE_W = 28,
  parameter int WORD_MAX = 24,
  parameter int CH_W     = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          fmt_sel,
  input logic [1:0]          width_sel,
  input logic                smp_valid,
  input logic [CH_W-1:0]     smp_chan,
  input logic [SAMPLE_W-1:0] smp_data
);

  localparam int PAD16 = WORD_MAX - 16;
  localparam int PAD20 = WORD_MAX - 20;

  logic [SAMPLE_W-WORD_MAX:0] top_bits;
  assign top_bits = smp_data[SAMPLE_W-1:WORD_MAX-1];

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  // R9
  sign_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ((&top_bits) || !(|top_bits)));

  // R8
  pad16_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(width_sel) == 2'd0) |-> (smp_data[PAD16-1:0] == '0));

  // R8
  pad20_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(width_sel) == 2'd1) |-> (smp_data[PAD20-1:0] == '0));

  // R7
  slot8_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(fmt_sel) == 3'd3) |-> (smp_chan < CH_W'(8)));

  // R3
  two_ch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(fmt_sel) < 3'd3) |-> (smp_chan <= CH_W'(1)));

  // R12
  bad_fmt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ($past(fmt_sel) <= 3'd4));

endmodule

bind aud_serial_rx asrx_chk #(
  .SAMPLE_W (SAMPLE_W),
  .WORD_MAX (WORD_MAX),
  .CH_W     (CH_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .fmt_sel   (fmt_sel),
  .width_sel (width_sel),
  .smp_valid (smp_valid),
  .smp_chan  (smp_chan),
  .smp_data  (smp_data)
);

// File: tb/aud_serial_rx_tb.sv
module aud_serial_rx_tb_top;

  logic        clk;
  logic        rst_n, bit_clk, frame_clk, ser_data;
  logic [2:0]  fmt_sel;
  logic [1:0]  width_sel;
  logic        smp_valid;
  logic [3:0]  smp_chan;
  logic [27:0] smp_data;

  int n_vec = 0;
  int n_bad = 0;

  logic [3:0]  exp_ch[$];
  logic [27:0] exp_dt[$];
  logic [3:0]  got_ch[$];
  logic [27:0] got_dt[$];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  aud_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_clk(frame_clk),
    .ser_data(ser_data), .fmt_sel(fmt_sel), .width_sel(width_sel),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1 && smp_valid === 1'b1) begin
      got_ch.push_back(smp_chan);
      got_dt.push_back(smp_data);
    end
  end

  function automatic int width_of(input logic [1:0] ws);
    return (ws == 2'd0) ? 16 : (ws == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic [23:0] make_word(input int idx, input int wb);
    logic [23:0] m;
    m = (24'h1 << wb) - 24'h1;
    if (idx == 0) return 24'h1 << (wb - 1);
    if (idx == 1) return (24'h1 << (wb - 1)) - 24'h1;
    return 24'($urandom) & m;
  endfunction

  function automatic logic [27:0] expect_smp(input logic [23:0] w, input int wb);
    logic [23:0] a;
    a = w << (24 - wb);
    return {{4{a[23]}}, a};
  endfunction

  task automatic bit_out(input logic lr, input logic sd);
    frame_clk = lr;
    ser_data  = sd;
    bit_clk   = 1'b0;
    repeat (4) @(negedge clk);
    bit_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_clk = 1'b0; frame_clk = 1'b0; ser_data = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_ch.delete(); exp_dt.delete(); got_ch.delete(); got_dt.delete();
  endtask

  task automatic compare(input string tag);
    int n;
    repeat (12) @(negedge clk);
    n_vec++;
    if (got_ch.size() != exp_ch.size()) begin
      n_bad++;
      $display("FAIL %s/R10 sample count: actual %0d expected %0d", tag, got_ch.size(), exp_ch.size());
    end
    n = (got_ch.size() < exp_ch.size()) ? got_ch.size() : exp_ch.size();
    for (int i = 0; i < n; i++) begin
      n_vec++;
      if (got_ch[i] !== exp_ch[i] || got_dt[i] !== exp_dt[i]) begin
        n_bad++;
        $display("FAIL %s/R9/R11 sample %0d: actual ch %0d data %h expected ch %0d data %h",
                 tag, i, got_ch[i], got_dt[i], exp_ch[i], exp_dt[i]);
      end
    end
  endtask

  // Two-channel framing; bad_fmt replaces the format code but keeps I2S stimulus
  task automatic run_2ch(input logic [2:0] fmt, input logic [1:0] ws, input logic [2:0] code,
                         input string tag);
    int wb, st;
    logic first_lr, lr, sd;
    logic [23:0] w;
    wb = width_of(ws);
    fmt_sel = code; width_sel = ws;
    do_reset();
    first_lr = (fmt == 3'd0) ? 1'b0 : 1'b1;
    st = (fmt == 3'd0) ? 1 : (fmt == 3'd1) ? 0 : 32 - wb;
    // R2: long idle at the opposite level, no frame may open
    for (int i = 0; i < 40; i++) bit_out(~first_lr, 1'($urandom));
    for (int f = 0; f < 3; f++) begin
      for (int h = 0; h < 2; h++) begin
        lr = h ? ~first_lr : first_lr;
        w  = make_word(f * 2 + h, wb);
        if (code <= 3'd4) begin
          exp_ch.push_back(4'(h));
          exp_dt.push_back(expect_smp(w, wb));
        end
        for (int k = 0; k < 32; k++) begin
          if (k >= st && k < st + wb) sd = w[wb - 1 - (k - st)];
          else sd = 1'($urandom);
          bit_out(lr, sd);
        end
      end
    end
    compare(tag);
  endtask

  task automatic run_tdm(input logic [2:0] fmt, input logic [1:0] ws, input int nsl,
                         input string tag);
    int wb, keep;
    logic sd;
    logic [23:0] w;
    wb = width_of(ws);
    keep = (fmt == 3'd3) ? 8 : 16;
    fmt_sel = fmt; width_sel = ws;
    do_reset();
    for (int i = 0; i < 4; i++) bit_out(1'b0, 1'($urandom));
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < nsl; s++) begin
        w = make_word(f * nsl + s, wb);
        if (s < keep) begin
          exp_ch.push_back(4'(s));
          exp_dt.push_back(expect_smp(w, wb));
        end
        for (int k = 0; k < 32; k++) begin
          sd = (k < wb) ? w[wb - 1 - k] : 1'($urandom);
          bit_out((s == 0) && (k == 0), sd);
        end
      end
    end
    compare(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fmt_sel = 3'd0; width_sel = 2'd0;
    rst_n = 1'b0; bit_clk = 1'b0; frame_clk = 1'b0; ser_data = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset and right after release
    n_vec++;
    if (smp_valid !== 1'b0 || smp_chan !== 4'd0 || smp_data !== 28'd0) begin
      n_bad++;
      $display("FAIL R1 in reset: actual %b %h %h expected 0 0 0", smp_valid, smp_chan, smp_data);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (smp_valid !== 1'b0 || smp_chan !== 4'd0 || smp_data !== 28'd0) begin
      n_bad++;
      $display("FAIL R1 after release: actual %b %h %h expected 0 0 0", smp_valid, smp_chan, smp_data);
    end

    for (int ws = 0; ws < 3; ws++) begin
      run_2ch(3'd0, 2'(ws), 3'd0, "R2/R3");
      run_2ch(3'd1, 2'(ws), 3'd1, "R4");
      run_2ch(3'd2, 2'(ws), 3'd2, "R5");
      run_tdm(3'd3, 2'(ws), 8, "R6");
    end
    run_2ch(3'd1, 2'd3, 3'd1, "R8");
    run_tdm(3'd4, 2'd2, 16, "R6");
    run_tdm(3'd4, 2'd0, 16, "R6");
    run_tdm(3'd3, 2'd1, 16, "R7");
    run_2ch(3'd0, 2'd2, 3'd5, "R12");
    run_2ch(3'd0, 2'd0, 3'd7, "R12");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule